// File: doc/BRIEF.md
# Write-Protection Key Sequencer

This block watches the stream of latched write commands headed for a byte-wide non-volatile array and decides, write by write, whether each one may reach the array. A write command is an address and a data byte presented with a one-cycle valid strobe. A small state machine looks for fixed address/data keys inside one load window. The window is the burst of back-to-back writes that ends when the load timer expires. Two keys exist. A three-write "set" key turns protection on and also opens the rest of the same window for data. A six-write "clear" key turns protection off.

Protection changes take effect when the load window closes, which stands for the start of the programming cycle. The protect flag models a non-volatile bit. Reset gives the delivered state, which is unprotected. A load strobe restores a saved value, as the array's persistent bit would be recovered after power-up. The permit and abort outputs are combinational on the write in the current cycle. The protect output is registered.

Top module: `wp_key_guard`

## Requirements
- R1: After reset the protect output is 0, and with no write presented the permit and abort outputs are 0.
- R2: The set key is data AAh at address 5555h, then 55h at 2AAAh, then A0h at 5555h, all in one window. It makes the protect output 1 in the cycle after the window-timeout strobe.
- R3: Writes that follow a completed set key in the same window are permitted whatever the protect state. The protect output stays (or becomes) 1.
- R4: The clear key is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h, all in one window. It makes the protect output 0 in the cycle after the window-timeout strobe.
- R5: While protect is 1, a write is not permitted unless a set key has completed earlier in the same window. This includes the writes that form a key.
- R6: While protect is 0, every write is permitted in its own cycle, key steps included. The exception is the write that completes a set or clear key, which is consumed and not permitted.
- R7: A write that breaks a partly matched key pulses abort in its own cycle and restarts matching. If the breaking write is AAh@5555h, it counts as the first step of a new key.
- R8: The window-timeout strobe returns the matcher to idle and closes an opened window. A key split across two windows has no effect.
- R9: The init-load strobe loads the protect output from the init value in the next cycle. It discards any change that has not yet been committed and returns the matcher to idle.
- R10: Without a timeout or init-load strobe, the protect output does not change.
- R11: A write presented in the same cycle as the timeout strobe belongs to the closing window. If it completes a key, that key is committed at the same close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_load | input | 1 | Restore protect flag from init_value |
| init_value | input | 1 | Saved protect flag value |
| win_timeout | input | 1 | Load window closed (programming starts) |
| wr_valid | input | 1 | Latched write command present this cycle |
| wr_addr | input | 15 | Write address |
| wr_data | input | 8 | Write data byte |
| protect_o | output | 1 | Current committed protect state |
| permit_o | output | 1 | This cycle's write may reach the array |
| abort_o | output | 1 | This cycle's write broke a partial key |

## Verification
Directed sequences run each key cleanly. They also run the set key while protected with data behind it, which separates unlocking from setting. Other sequences insert breaking writes, including a repeated AAh@5555h, to tell a plain restart from a restart that reuses the breaking write as step one. A key split by a timeout shows that matching does not cross windows. A key completed on the timeout cycle shows which window such a write belongs to. Constrained-random traffic is weighted toward the key bytes. It is checked against a reference model in the bench and mixes in timeouts and init loads, so that partial keys are often cut at every step.

// File: rtl/wp_pkg.sv
package wp_pkg;

  // Matcher progress: how many key steps have been seen in this window.
  typedef enum logic [2:0] {
    KS_IDLE  = 3'd0,
    KS_LEAD  = 3'd1,  // first lead byte seen
    KS_CONF  = 3'd2,  // first confirm byte seen
    KS_ARM   = 3'd3,  // clear-arm byte seen
    KS_LEAD2 = 3'd4,  // second lead byte seen
    KS_CONF2 = 3'd5,  // second confirm byte seen
    KS_OPEN  = 3'd6   // set key complete, window open for data
  } key_state_t;

  // Classification of one write against the key alphabet.
  typedef enum logic [2:0] {
    KC_OTHER = 3'd0,
    KC_LEAD  = 3'd1,
    KC_CONF  = 3'd2,
    KC_SET   = 3'd3,
    KC_ARM   = 3'd4,
    KC_CLEAR = 3'd5
  } key_class_t;

endpackage

// File: rtl/wp_matcher.sv
module wp_matcher
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_P = 15'h5555,
  parameter logic [ADDR_W-1:0] ADDR_Q = 15'h2AAA,
  parameter logic [DATA_W-1:0] D_LEAD = 8'hAA,
  parameter logic [DATA_W-1:0] D_CONF = 8'h55,
  parameter logic [DATA_W-1:0] D_SET  = 8'hA0,
  parameter logic [DATA_W-1:0] D_ARM  = 8'h80,
  parameter logic [DATA_W-1:0] D_CLR  = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_load,
  input  logic              win_timeout,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              open_o,
  output logic              set_done_o,
  output logic              clr_done_o,
  output logic              abort_o
);

  key_state_t state_q, state_d;
  key_class_t cls;

  function automatic key_class_t classify(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    if (a == ADDR_P && d == D_LEAD)  return KC_LEAD;
    if (a == ADDR_Q && d == D_CONF)  return KC_CONF;
    if (a == ADDR_P && d == D_SET)   return KC_SET;
    if (a == ADDR_P && d == D_ARM)   return KC_ARM;
    if (a == ADDR_P && d == D_CLR)   return KC_CLEAR;
    return KC_OTHER;
  endfunction

  // Where a broken key resumes: a lead byte starts a fresh key.
  function automatic key_state_t restart(key_class_t c);
    return (c == KC_LEAD) ? KS_LEAD : KS_IDLE;
  endfunction

  assign cls = classify(wr_addr, wr_data);

  logic       step_ok;
  key_state_t step_next;

  always_comb begin
    step_ok   = 1'b0;
    step_next = state_q;
    unique case (state_q)
      KS_IDLE:  begin step_ok = (cls == KC_LEAD); step_next = restart(cls); end
      KS_LEAD:  begin step_ok = (cls == KC_CONF); step_next = step_ok ? KS_CONF : restart(cls); end
      KS_CONF:  begin
        step_ok   = (cls == KC_SET) || (cls == KC_ARM);
        step_next = (cls == KC_SET) ? KS_OPEN : (cls == KC_ARM) ? KS_ARM : restart(cls);
      end
      KS_ARM:   begin step_ok = (cls == KC_LEAD); step_next = step_ok ? KS_LEAD2 : restart(cls); end
      KS_LEAD2: begin step_ok = (cls == KC_CONF); step_next = step_ok ? KS_CONF2 : restart(cls); end
      KS_CONF2: begin step_ok = (cls == KC_CLEAR); step_next = step_ok ? KS_IDLE : restart(cls); end
      KS_OPEN:  begin step_ok = 1'b1; step_next = KS_OPEN; end
      default:  begin step_ok = 1'b0; step_next = KS_IDLE; end
    endcase
  end

  assign open_o     = (state_q == KS_OPEN);
  assign set_done_o = wr_valid && (state_q == KS_CONF) && (cls == KC_SET);
  assign clr_done_o = wr_valid && (state_q == KS_CONF2) && (cls == KC_CLEAR);
  assign abort_o    = wr_valid && (state_q != KS_IDLE) && (state_q != KS_OPEN) && !step_ok;

  always_comb begin
    state_d = state_q;
    if (wr_valid) state_d = step_next;
    if (init_load || win_timeout) state_d = KS_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= KS_IDLE;
    else        state_q <= state_d;
  end

  // R8: a timeout or init load always leaves the matcher idle.
  assert_close_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_timeout || init_load) |=> (state_q == KS_IDLE));

  // R8: an opened window stays open until it closes.
  assert_open_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && !win_timeout && !init_load) |=> open_o);

  // R7: abort only ever accompanies a write.
  assert_abort_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> wr_valid);

  // R2: a finished set key opens the window unless it is closing now.
  assert_set_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_done_o && !win_timeout && !init_load) |=> open_o);

endmodule

// File: rtl/wp_store.sv
module wp_store #(
  parameter logic PROT_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_load,
  input  logic init_value,
  input  logic win_timeout,
  input  logic set_done,
  input  logic clr_done,
  output logic protect_o
);

  logic prot_q, pend_v_q, pend_val_q;
  logic pend_v_d, pend_val_d, prot_d;

  // Pending change after this cycle's key result (latest key wins).
  always_comb begin
    pend_v_d   = pend_v_q;
    pend_val_d = pend_val_q;
    if (set_done) begin pend_v_d = 1'b1; pend_val_d = 1'b1; end
    if (clr_done) begin pend_v_d = 1'b1; pend_val_d = 1'b0; end
  end

  always_comb begin
    prot_d = prot_q;
    if (init_load)                    prot_d = init_value;
    else if (win_timeout && pend_v_d) prot_d = pend_val_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_q     <= PROT_RESET;
      pend_v_q   <= 1'b0;
      pend_val_q <= 1'b0;
    end else begin
      prot_q     <= prot_d;
      pend_v_q   <= (init_load || win_timeout) ? 1'b0 : pend_v_d;
      pend_val_q <= pend_val_d;
    end
  end

  assign protect_o = prot_q;

  // R10: no change to the flag without a close or a load.
  assert_protect_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_timeout && !init_load) |=> $stable(prot_q));

  // R9: a load takes the init value.
  assert_init_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_load |=> (prot_q == $past(init_value)));

  // R11: a key finished on the closing cycle is committed at that close.
  assert_close_commits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (win_timeout && !init_load && set_done) |=> prot_q);

endmodule

// File: rtl/wp_gate.sv
module wp_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_valid,
  input  logic protect,
  input  logic window_open,
  input  logic key_done,
  output logic permit_o
);

  // Open window passes everything; otherwise only unprotected, unconsumed writes.
  assign permit_o = wr_valid && (window_open || (!protect && !key_done));

  // R5: locked and not opened means nothing reaches the array.
  assert_locked_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (protect && !window_open) |-> !permit_o);

  // R6: the write that completes a key is consumed.
  assert_key_consumed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    key_done |-> !permit_o);

endmodule

// File: rtl/wp_key_guard.sv
module wp_key_guard #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_P = 15'h5555,
  parameter logic [ADDR_W-1:0] ADDR_Q = 15'h2AAA,
  parameter logic [DATA_W-1:0] D_LEAD = 8'hAA,
  parameter logic [DATA_W-1:0] D_CONF = 8'h55,
  parameter logic [DATA_W-1:0] D_SET  = 8'hA0,
  parameter logic [DATA_W-1:0] D_ARM  = 8'h80,
  parameter logic [DATA_W-1:0] D_CLR  = 8'h20,
  parameter logic PROT_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_load,
  input  logic              init_value,
  input  logic              win_timeout,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              protect_o,
  output logic              permit_o,
  output logic              abort_o
);

  logic window_open, set_done, clr_done, key_done;

  wp_matcher #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_P(ADDR_P), .ADDR_Q(ADDR_Q),
    .D_LEAD(D_LEAD), .D_CONF(D_CONF), .D_SET(D_SET), .D_ARM(D_ARM), .D_CLR(D_CLR)
  ) matcher_i (
    .clk(clk), .rst_n(rst_n), .init_load(init_load), .win_timeout(win_timeout),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .open_o(window_open), .set_done_o(set_done), .clr_done_o(clr_done), .abort_o(abort_o)
  );

  wp_store #(.PROT_RESET(PROT_RESET)) store_i (
    .clk(clk), .rst_n(rst_n), .init_load(init_load), .init_value(init_value),
    .win_timeout(win_timeout), .set_done(set_done), .clr_done(clr_done),
    .protect_o(protect_o)
  );

  assign key_done = set_done || clr_done;

  wp_gate gate_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .protect(protect_o),
    .window_open(window_open), .key_done(key_done), .permit_o(permit_o)
  );

  // R3: an opened window passes every write.
  assert_open_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (window_open && wr_valid) |-> permit_o);

endmodule

// File: tb/wp_key_guard_tb.sv
module wp_key_guard_tb_top;
  localparam logic [14:0] KP = 15'h5555;
  localparam logic [14:0] KQ = 15'h2AAA;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, init_load, init_value, win_timeout, wr_valid;
  logic [14:0] wr_addr;
  logic [7:0]  wr_data;
  logic protect_o, permit_o, abort_o;

  wp_key_guard dut_i (
    .clk(clk), .rst_n(rst_n), .init_load(init_load), .init_value(init_value),
    .win_timeout(win_timeout), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .protect_o(protect_o), .permit_o(permit_o), .abort_o(abort_o)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  int m_step = 0;            // 0 idle, 1..5 partial, 6 open
  bit m_prot = 0, m_pv = 0, m_pval = 0;

  // 1 lead, 2 confirm, 3 set, 4 arm, 5 clear, 0 other
  function automatic int kind(logic [14:0] a, logic [7:0] d);
    if (a == KP && d == 8'hAA) return 1;
    if (a == KQ && d == 8'h55) return 2;
    if (a == KP && d == 8'hA0) return 3;
    if (a == KP && d == 8'h80) return 4;
    if (a == KP && d == 8'h20) return 5;
    return 0;
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit v, logic [14:0] a, logic [7:0] d, bit to, bit il, bit iv, string req);
    int k, nxt;
    bit ab, en, dis, ep;
    wr_valid = v; wr_addr = a; wr_data = d;
    win_timeout = to; init_load = il; init_value = iv;
    k = kind(a, d); nxt = m_step; ab = 0; en = 0; dis = 0;
    if (v) begin
      case (m_step)
        0: nxt = (k == 1) ? 1 : 0;
        1: if (k == 2) nxt = 2; else ab = 1;
        2: if (k == 3) begin nxt = 6; en = 1; end
           else if (k == 4) nxt = 3; else ab = 1;
        3: if (k == 1) nxt = 4; else ab = 1;
        4: if (k == 2) nxt = 5; else ab = 1;
        5: if (k == 5) begin nxt = 0; dis = 1; end else ab = 1;
        default: nxt = 6;
      endcase
      if (ab) nxt = (k == 1) ? 1 : 0;
    end
    ep = v && (m_step == 6 || (!m_prot && !en && !dis));
    @(negedge clk);
    check(req, "permit", permit_o, ep);
    check(req, "abort", abort_o, ab);
    check(req, "protect", protect_o, m_prot);
    @(posedge clk); #1;
    if (en)  begin m_pv = 1; m_pval = 1; end
    if (dis) begin m_pv = 1; m_pval = 0; end
    m_step = nxt;
    if (il) begin m_prot = iv; m_pv = 0; m_step = 0; end
    else if (to) begin if (m_pv) m_prot = m_pval; m_pv = 0; m_step = 0; end
    wr_valid = 0; win_timeout = 0; init_load = 0;
  endtask

  task automatic wr(logic [14:0] a, logic [7:0] d, string req);
    cyc(1, a, d, 0, 0, 0, req);
  endtask
  task automatic close(string req);
    cyc(0, '0, '0, 1, 0, 0, req);
  endtask
  task automatic idle(string req);
    cyc(0, '0, '0, 0, 0, 0, req);
  endtask
  task automatic set_key(string req);
    wr(KP, 8'hAA, req); wr(KQ, 8'h55, req); wr(KP, 8'hA0, req);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; init_load = 0; init_value = 0; win_timeout = 0;
    wr_valid = 0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle("R1");
    check("R1", "protect after reset", protect_o, 1'b0);

    // R6: unprotected data passes; set key steps pass except the last
    wr(15'h1234, 8'h5A, "R6");
    set_key("R6");
    wr(15'h0040, 8'h11, "R3");
    check("R10", "protect mid-window", protect_o, 1'b0);
    close("R2");
    idle("R2");
    check("R2", "protect set after close", protect_o, 1'b1);

    // R5: protected, no key
    wr(15'h0100, 8'h77, "R5");
    wr(KP, 8'hAA, "R5");
    close("R5");

    // R3: set key while protected unlocks the rest of the window
    set_key("R3");
    wr(15'h7FFF, 8'h01, "R3");
    wr(KP, 8'hAA, "R3");
    wr(15'h0000, 8'hFF, "R3");
    close("R3");

    // R7: break after two steps; then AA repeated counts as a new step one
    wr(KP, 8'hAA, "R7"); wr(KQ, 8'h55, "R7"); wr(KP, 8'h33, "R7");
    wr(KP, 8'hAA, "R7"); wr(KP, 8'hAA, "R7"); wr(KQ, 8'h55, "R7"); wr(KP, 8'hA0, "R7");
    wr(15'h0222, 8'h22, "R7");
    close("R7");

    // R8: key split by a timeout does nothing
    wr(KP, 8'hAA, "R8"); wr(KQ, 8'h55, "R8");
    close("R8");
    wr(KP, 8'hA0, "R8");
    wr(15'h0333, 8'h33, "R8");
    close("R8");

    // R4: clear key
    wr(KP, 8'hAA, "R4"); wr(KQ, 8'h55, "R4"); wr(KP, 8'h80, "R4");
    wr(KP, 8'hAA, "R4"); wr(KQ, 8'h55, "R4"); wr(KP, 8'h20, "R4");
    check("R10", "protect before close", protect_o, 1'b1);
    close("R4");
    idle("R4");
    check("R4", "protect cleared", protect_o, 1'b0);

    // R11: key completed on the closing cycle
    wr(KP, 8'hAA, "R11"); wr(KQ, 8'h55, "R11");
    cyc(1, KP, 8'hA0, 1, 0, 0, "R11");
    idle("R11");
    check("R11", "protect committed", protect_o, 1'b1);

    // R9: init load and pending discard
    cyc(0, '0, '0, 0, 1, 0, "R9");
    idle("R9");
    check("R9", "loaded 0", protect_o, 1'b0);
    set_key("R9");
    cyc(0, '0, '0, 0, 1, 0, "R9");
    close("R9");
    check("R9", "pending discarded", protect_o, 1'b0);
    cyc(0, '0, '0, 0, 1, 1, "R9");
    idle("R9");
    check("R9", "loaded 1", protect_o, 1'b1);

    // Random traffic weighted to key bytes
    void'($urandom(32'd4242));
    for (int i = 0; i < 4000; i++) begin
      int r, sel;
      logic [14:0] a;
      logic [7:0] d;
      r = $urandom_range(0, 99);
      sel = $urandom_range(0, 4);
      case (sel)
        0: begin a = KP; d = 8'hAA; end
        1: begin a = KQ; d = 8'h55; end
        2: begin a = KP; d = 8'hA0; end
        3: begin a = KP; d = 8'h80; end
        default: begin a = KP; d = 8'h20; end
      endcase
      if (r < 30) begin a = 15'($urandom); d = 8'($urandom); end
      if (r < 85)      cyc(1, a, d, (r % 13) == 0, 0, 0, "R5/R6/R7 random");
      else if (r < 93) cyc(0, '0, '0, 1, 0, 0, "R8 random");
      else if (r < 95) cyc(r[0], a, d, 0, 1, r[1], "R9 random");
      else             cyc(0, '0, '0, 0, 0, 0, "R10 random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule